// File: doc/BRIEF.md
# Load/Store Byte-Lane Formatter

This block sits between a processor core and a 32-bit word-wide data memory. It handles sub-word accesses. On a store it writes the byte, halfword or word operand into every lane position it could occupy. It then raises the byte enables of only the lanes the low address bits select. On a load it takes the full memory word, picks out the addressed byte or halfword, and extends it with the sign bit or with zeros. A separate upper-immediate path forms a result from a 16-bit constant without touching memory.

A mode input chooses the byte order while the block runs. With the input low, offset 0 is the most significant lane (big-endian). With it high, offset 0 is the least significant lane (little-endian). An access whose address does not suit its size is flagged, and the write is suppressed. Every output is registered, so results appear one clock after the request.

Top module: `lsfmt_top`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, every output is zero.
- R2: Lane i is `mem_wdata[8i+7:8i]`. Byte offset k maps to lane 3-k when `le_mode`=0 and to lane k when `le_mode`=1. A byte store (`req_size`=0) puts `store_data[7:0]` in all four lanes and sets exactly one enable bit, the one for the addressed lane.
- R3: A halfword store (`req_size`=1) puts `store_data[15:0]` in both halves of `mem_wdata`. It enables the two lanes holding offsets a and a+1: `4'b1100` for offset 0 big-endian or offset 2 little-endian, otherwise `4'b0011`.
- R4: A word store (`req_size`=2, or the value 3, which is treated as word) passes `store_data` through unchanged with `mem_be`=`4'b1111`.
- R5: A byte load returns the addressed byte of `mem_rdata`. The value is sign-extended when `req_unsigned`=0 and zero-extended when `req_unsigned`=1.
- R6: A halfword load assembles offsets a (upper byte when big-endian, lower when little-endian) and a+1. The value is then sign-extended or zero-extended as selected by `req_unsigned`.
- R7: A word load returns `mem_rdata` unchanged.
- R8: When `req_lui`=1 the result is `{lui_imm, 16'h0000}` with `result_valid`=1. No write occurs, no misalignment is reported, and size, store and address inputs have no effect.
- R9: A halfword access with `addr_lo[0]`=1, or a word access with `addr_lo`≠0, sets `misalign`. It then forces `mem_we`=0 and `mem_be`=0, and a load returns zero.
- R10: Outputs reflect a request one clock after it is sampled. A cycle with `req_valid`=0 produces `mem_we`=0, `result_valid`=0 and `misalign`=0.
- R11: `le_mode` may change between consecutive requests, and each request uses the value sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| le_mode | input | 1 | 0 selects big-endian lanes, 1 selects little-endian |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 for store, 0 for load |
| req_lui | input | 1 | Upper-immediate operation (overrides store/load) |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| addr_lo | input | 2 | Low two address bits |
| store_data | input | 32 | Store operand, right-aligned |
| lui_imm | input | 16 | Immediate for the upper-immediate path |
| mem_rdata | input | 32 | Word read from memory for this load |
| mem_we | output | 1 | Memory write strobe |
| mem_be | output | 4 | Byte enables, bit i for lane i |
| mem_wdata | output | 32 | Lane-formatted write data |
| load_result | output | 32 | Extended load or upper-immediate result |
| result_valid | output | 1 | Load or upper-immediate result present |
| misalign | output | 1 | Access size and address disagree |

## Verification
The bench walks every offset in both byte orders. A formatter that reversed the lane mapping, or that ignored the mode input, therefore enables the wrong lane or returns the mirror byte. Loads use a memory word whose bytes carry alternating sign bits. Swapping signed and unsigned extension, or extending from the wrong bit of a halfword, shows up as wrong upper bits. Misaligned halfword and word accesses at each bad offset check that the write is blocked. A design that only flagged the error would still strobe the memory. The upper-immediate path is driven with the store and size inputs set to disturbing values, to catch a result that leaks them.

// File: rtl/lsfmt_pkg.sv
package lsfmt_pkg;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int OFS_W  = $clog2(LANES);
    localparam int HALF_W = WORD_W / 2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRSV = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic              we;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic              valid;
        logic              misalign;
    } fmt_out_s;
endpackage

// File: rtl/lsfmt_store.sv
module lsfmt_store
    import lsfmt_pkg::*;
(
    input  logic              le_mode,
    input  logic [1:0]        size_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] data_o
);
    logic [OFS_W-1:0] byte_lane;
    logic             upper_half;

    // replicate the operand into every lane it could land in
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            case (size_i)
                SZ_BYTE: data_o[i*LANE_W +: LANE_W] = data_i[LANE_W-1:0];
                SZ_HALF: data_o[i*LANE_W +: LANE_W] = data_i[(i%2)*LANE_W +: LANE_W];
                default: data_o[i*LANE_W +: LANE_W] = data_i[i*LANE_W +: LANE_W];
            endcase
        end
    end

    always_comb begin
        byte_lane  = le_mode ? ofs_i : ~ofs_i;
        upper_half = le_mode ? ofs_i[OFS_W-1] : ~ofs_i[OFS_W-1];
        case (size_i)
            SZ_BYTE: be_o = LANES'(1) << byte_lane;
            SZ_HALF: be_o = upper_half ? {2'b11, {(LANES-2){1'b0}}}
                                       : {{(LANES-2){1'b0}}, 2'b11};
            default: be_o = '1;
        endcase
    end
endmodule

// File: rtl/lsfmt_load.sv
module lsfmt_load
    import lsfmt_pkg::*;
(
    input  logic              le_mode,
    input  logic [1:0]        size_i,
    input  logic              unsigned_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] value_o
);
    logic [OFS_W-1:0]  lane;
    logic [LANE_W-1:0] byte_v;
    logic [HALF_W-1:0] half_v;
    logic              upper_half;

    always_comb begin
        lane       = le_mode ? ofs_i : ~ofs_i;
        upper_half = le_mode ? ofs_i[OFS_W-1] : ~ofs_i[OFS_W-1];
        byte_v     = word_i[{lane, 3'b000} +: LANE_W];
        half_v     = upper_half ? word_i[WORD_W-1:HALF_W] : word_i[HALF_W-1:0];
        case (size_i)
            SZ_BYTE: value_o = {{(WORD_W-LANE_W){byte_v[LANE_W-1] & ~unsigned_i}}, byte_v};
            SZ_HALF: value_o = {{(WORD_W-HALF_W){half_v[HALF_W-1] & ~unsigned_i}}, half_v};
            default: value_o = word_i;
        endcase
    end
endmodule

// File: rtl/lsfmt_top.sv
module lsfmt_top
    import lsfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              le_mode,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic              req_lui,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [1:0]        addr_lo,
    input  logic [31:0]       store_data,
    input  logic [15:0]       lui_imm,
    input  logic [31:0]       mem_rdata,
    output logic              mem_we,
    output logic [3:0]        mem_be,
    output logic [31:0]       mem_wdata,
    output logic [31:0]       load_result,
    output logic              result_valid,
    output logic              misalign
);
    fmt_out_s          out_d, out_q;
    logic [LANES-1:0]  st_be;
    logic [WORD_W-1:0] st_data;
    logic [WORD_W-1:0] ld_value;
    logic              bad_align;
    logic              is_mem;

    lsfmt_store u_store (
        .le_mode (le_mode),
        .size_i  (req_size),
        .ofs_i   (addr_lo),
        .data_i  (store_data),
        .be_o    (st_be),
        .data_o  (st_data)
    );

    lsfmt_load u_load (
        .le_mode    (le_mode),
        .size_i     (req_size),
        .unsigned_i (req_unsigned),
        .ofs_i      (addr_lo),
        .word_i     (mem_rdata),
        .value_o    (ld_value)
    );

    always_comb begin
        case (req_size)
            SZ_BYTE: bad_align = 1'b0;
            SZ_HALF: bad_align = addr_lo[0];
            default: bad_align = |addr_lo;
        endcase
        is_mem = req_valid & ~req_lui;

        out_d          = '0;
        out_d.misalign = is_mem & bad_align;
        out_d.valid    = req_valid & (req_lui | ~req_store);
        if (req_valid && req_lui) begin
            out_d.rdata = {lui_imm, {HALF_W{1'b0}}};
        end else if (is_mem && !bad_align) begin
            if (req_store) begin
                out_d.we    = 1'b1;
                out_d.be    = st_be;
                out_d.wdata = st_data;
            end else begin
                out_d.rdata = ld_value;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign mem_we       = out_q.we;
    assign mem_be       = out_q.be;
    assign mem_wdata    = out_q.wdata;
    assign load_result  = out_q.rdata;
    assign result_valid = out_q.valid;
    assign misalign     = out_q.misalign;

    p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_lui && req_size == SZ_BYTE)
        |=> (mem_we && $countones(mem_be) == 1));

    p_word_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !req_lui && req_size[1] && addr_lo == 2'b00)
        |=> (mem_be == 4'hF && mem_wdata == $past(store_data)));

    p_lui_upper_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_lui)
        |=> (load_result[15:0] == 16'h0 && !mem_we && !misalign && result_valid));

    p_misalign_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (!mem_we && mem_be == '0));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!mem_we && !result_valid && !misalign));
endmodule

// File: tb/test_lsfmt_top.sv
module test_lsfmt_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        le_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_store = 1'b0;
    logic        req_lui = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic        req_unsigned = 1'b0;
    logic [1:0]  addr_lo = 2'd0;
    logic [31:0] store_data = '0;
    logic [15:0] lui_imm = '0;
    logic [31:0] mem_rdata = '0;
    logic        mem_we;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] load_result;
    logic        result_valid;
    logic        misalign;

    int n_vec = 0;
    int n_bad = 0;
    logic done = 1'b0;

    localparam logic [31:0] RD = 32'h81_72_F3_04;

    always #10 clk = ~clk;

    lsfmt_top i_lsfmt_top (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int lane_of(input logic le, input int ofs);
        return le ? ofs : 3 - ofs;
    endfunction

    function automatic logic [7:0] mem_byte(input logic [31:0] w, input logic le, input int ofs);
        return w[8*lane_of(le, ofs) +: 8];
    endfunction

    task automatic issue(input logic st, input logic lui, input logic [1:0] sz,
                         input logic uns, input logic [1:0] a, input logic le,
                         input logic [31:0] sd, input logic [15:0] imm, input logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_store = st; req_lui = lui; req_size = sz;
        req_unsigned = uns; addr_lo = a; le_mode = le;
        store_data = sd; lui_imm = imm; mem_rdata = rd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 we",   {31'b0, mem_we}, 0);
        chk("R1 be",   {28'b0, mem_be}, 0);
        chk("R1 wd",   mem_wdata, 0);
        chk("R1 res",  load_result, 0);
        chk("R1 vld",  {31'b0, result_valid}, 0);
        chk("R1 mis",  {31'b0, misalign}, 0);
    endtask

    task automatic t_store_byte;
        for (int le = 0; le < 2; le++)
            for (int a = 0; a < 4; a++) begin
                issue(1, 0, 2'd0, 0, a[1:0], le[0], 32'h1234_56A5, 16'h0, 32'h0);
                chk("R2 we", {31'b0, mem_we}, 1);
                chk("R2 be", {28'b0, mem_be}, 32'(1) << lane_of(le[0], a));
                chk("R2 wd", mem_wdata, 32'hA5A5_A5A5);
            end
    endtask

    task automatic t_store_half;
        for (int le = 0; le < 2; le++)
            for (int a = 0; a < 4; a += 2) begin
                issue(1, 0, 2'd1, 0, a[1:0], le[0], 32'hDEAD_C31B, 16'h0, 32'h0);
                chk("R3 be", {28'b0, mem_be},
                    (32'(1) << lane_of(le[0], a)) | (32'(1) << lane_of(le[0], a + 1)));
                chk("R3 wd", mem_wdata, 32'hC31B_C31B);
            end
    endtask

    task automatic t_store_word;
        issue(1, 0, 2'd2, 0, 2'd0, 0, 32'h0BAD_F00D, 16'h0, 32'h0);
        chk("R4 be", {28'b0, mem_be}, 32'hF);
        chk("R4 wd", mem_wdata, 32'h0BAD_F00D);
        issue(1, 0, 2'd3, 0, 2'd0, 1, 32'h7654_3210, 16'h0, 32'h0);
        chk("R4 rsv be", {28'b0, mem_be}, 32'hF);
        chk("R4 rsv wd", mem_wdata, 32'h7654_3210);
    endtask

    task automatic t_load_byte;
        for (int le = 0; le < 2; le++)
            for (int a = 0; a < 4; a++)
                for (int u = 0; u < 2; u++) begin
                    logic [7:0] b;
                    b = mem_byte(RD, le[0], a);
                    issue(0, 0, 2'd0, u[0], a[1:0], le[0], 32'h0, 16'h0, RD);
                    chk("R5 res", load_result, u ? {24'h0, b} : {{24{b[7]}}, b});
                    chk("R5 vld", {31'b0, result_valid}, 1);
                end
    endtask

    task automatic t_load_half;
        for (int le = 0; le < 2; le++)
            for (int a = 0; a < 4; a += 2)
                for (int u = 0; u < 2; u++) begin
                    logic [15:0] h;
                    h = le ? {mem_byte(RD, 1, a + 1), mem_byte(RD, 1, a)}
                           : {mem_byte(RD, 0, a), mem_byte(RD, 0, a + 1)};
                    issue(0, 0, 2'd1, u[0], a[1:0], le[0], 32'h0, 16'h0, RD);
                    chk("R6 res", load_result, u ? {16'h0, h} : {{16{h[15]}}, h});
                end
    endtask

    task automatic t_load_word;
        issue(0, 0, 2'd2, 0, 2'd0, 0, 32'h0, 16'h0, RD);
        chk("R7 be-mode", load_result, RD);
        issue(0, 0, 2'd2, 1, 2'd0, 1, 32'h0, 16'h0, RD);
        chk("R7 le-mode", load_result, RD);
    endtask

    task automatic t_lui;
        issue(1, 1, 2'd1, 0, 2'd3, 0, 32'hFFFF_FFFF, 16'h9C40, RD);
        chk("R8 res", load_result, 32'h9C40_0000);
        chk("R8 we",  {31'b0, mem_we}, 0);
        chk("R8 mis", {31'b0, misalign}, 0);
        chk("R8 vld", {31'b0, result_valid}, 1);
    endtask

    task automatic t_misalign;
        issue(1, 0, 2'd1, 0, 2'd1, 0, 32'h1111_2222, 16'h0, 32'h0);
        chk("R9 half mis", {31'b0, misalign}, 1);
        chk("R9 half we",  {31'b0, mem_we}, 0);
        chk("R9 half be",  {28'b0, mem_be}, 0);
        for (int a = 1; a < 4; a++) begin
            issue(1, 0, 2'd2, 0, a[1:0], 1, 32'h3333_4444, 16'h0, 32'h0);
            chk("R9 word mis", {31'b0, misalign}, 1);
            chk("R9 word we",  {31'b0, mem_we}, 0);
        end
        issue(0, 0, 2'd1, 0, 2'd3, 0, 32'h0, 16'h0, RD);
        chk("R9 load res", load_result, 0);
        chk("R9 load mis", {31'b0, misalign}, 1);
    endtask

    task automatic t_idle;
        issue(1, 0, 2'd2, 0, 2'd0, 0, 32'h5555_AAAA, 16'h0, 32'h0);
        chk("R10 write seen", {31'b0, mem_we}, 1);
        @(negedge clk);
        chk("R10 idle we",  {31'b0, mem_we}, 0);
        chk("R10 idle vld", {31'b0, result_valid}, 0);
    endtask

    task automatic t_mode_switch;
        issue(1, 0, 2'd0, 0, 2'd1, 0, 32'h0000_0077, 16'h0, 32'h0);
        chk("R11 be lane", {28'b0, mem_be}, 32'h4);
        issue(1, 0, 2'd0, 0, 2'd1, 1, 32'h0000_0077, 16'h0, 32'h0);
        chk("R11 le lane", {28'b0, mem_be}, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_store_byte;
        t_store_half;
        t_store_word;
        t_load_byte;
        t_load_half;
        t_load_word;
        t_lui;
        t_misalign;
        t_idle;
        t_mode_switch;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule